// File: doc/BRIEF.md
# Ring Buffer Address Pointer Unit

This block holds the pointer state for one circular byte region: an inclusive lower bound, an exclusive upper bound and a stored current address. A transfer engine starts a transfer with a strobe. It then pulses an advance strobe once per byte and reads the byte address from the unit. At the end it pulses a finish strobe. The unit checks the stored address when the transfer starts, produces every byte address with wraparound, and can store the final address back when the transfer ends. It holds no data and converts no sample formats.

The unit has two modes, picked at each start. In ring mode the upper bound is an explicit register. A stored address at or beyond that bound is a fault: the unit raises an error and generates no addresses. In scratch mode the upper bound comes from a size-minus-one register, as base + size_m1 + 1. A stored address at or beyond that bound does not fault. Instead the transfer runs linearly without wrapping. In both modes a stored address below the base snaps up to the base. A transfer longer than the ring keeps wrapping and raises no flag, so it overwrites earlier bytes on output and re-reads them on input.

Top module: `ring_ptr_unit`

## Requirements
- R1: After reset, busy_o, err_o and done_o are 0, and addr_o and cur_o are 0.
- R2: A write with cfg_we loads cfg_wdata into the register picked by cfg_sel: 0 lower bound, 1 upper bound (ring mode), 2 stored current address (seen on cur_o), 3 scratch size minus one. A write while busy_o is 1 has no effect.
- R3: A start while idle, with the stored address at or above the base and below the active upper bound, sets busy_o in the next cycle with addr_o equal to the stored address.
- R4: A start with the stored address below the base begins the transfer with addr_o equal to the base.
- R5: Each advance while busy increments addr_o by one. An increment that would reach the upper bound loads the base instead, so in wrapping operation addr_o never equals the upper bound.
- R6: A transfer longer than the ring keeps wrapping with err_o held at 0.
- R7: In ring mode, a start with the stored address at or above the upper bound sets err_o in the next cycle and leaves busy_o at 0. Advances then leave addr_o unchanged. The next start that does not fault clears err_o.
- R8: In scratch mode the upper bound is base + size_m1 + 1, computed one bit wider than an address, so a region that ends at the top of the address space still wraps to the base.
- R9: In scratch mode, a start with the stored address at or above base + size_m1 + 1 runs linearly. addr_o increments without wrapping and err_o stays 0.
- R10: A finish while busy clears busy_o and pulses done_o for exactly one cycle. If writeback was requested at the start, cur_o takes the final address, including an advance in the finish cycle and any wrap. Without writeback, cur_o is unchanged.
- R11: A start while busy and an advance while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select (0 base, 1 end, 2 current, 3 size minus one) |
| cfg_wdata | input | AW | Register write data |
| start | input | 1 | Transfer start strobe |
| scratch_mode | input | 1 | Mode for this start: 1 scratch, 0 ring |
| wb_en | input | 1 | Store the final address when the transfer ends |
| step | input | 1 | Advance to the next byte address |
| finish | input | 1 | End of transfer strobe |
| busy_o | output | 1 | Transfer in progress |
| addr_o | output | AW | Byte address of the current access |
| err_o | output | 1 | Start-time pointer fault |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| cur_o | output | AW | Stored current address |

## Verification
Ring-mode transfers begin inside the ring, below the base and at the upper bound. These three starts separate the accept, snap and fault outcomes of the start check. Runs of advances longer than the ring show whether wrap happens at the bound and not one byte early or late, and whether an overrun stays silent. Scratch-mode starts inside and beyond base + size separate wrapping from linear runs. One scratch region ends at the top of the address space, which exposes a bound computed at address width. Transfers that end with and without writeback, with and without an advance in the finish cycle, show which value reaches the stored address.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_END  = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_SIZE = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        CLS_OK     = 2'd0,
        CLS_SNAP   = 2'd1,
        CLS_LINEAR = 2'd2,
        CLS_FAULT  = 2'd3
    } start_cls_e;

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_ptr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  cfg_sel_e      sel,
    input  logic [AW-1:0] wdata,
    input  logic          lock,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] ring_end_o,
    output logic [AW:0]   scr_lim_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] rend;
        logic [AW-1:0] size_m1;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && !lock) begin
            case (sel)
                SEL_BASE: cfg_d.base    = wdata;
                SEL_END:  cfg_d.rend    = wdata;
                SEL_SIZE: cfg_d.size_m1 = wdata;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_o     = cfg_q.base;
    assign ring_end_o = cfg_q.rend;
    assign scr_lim_o  = {1'b0, cfg_q.base} + {1'b0, cfg_q.size_m1} + {{AW{1'b0}}, 1'b1};

    // R2
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && we) |=> ($stable(cfg_q)));

endmodule

// File: rtl/ring_start_check.sv
module ring_start_check
    import ring_ptr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   lim_i,
    input  logic          scratch_i,
    output start_cls_e    cls_o,
    output logic [AW-1:0] ptr0_o
);
    always_comb begin
        ptr0_o = cur_i;
        if ({1'b0, cur_i} >= lim_i) begin
            cls_o = scratch_i ? CLS_LINEAR : CLS_FAULT;
        end else if (cur_i < base_i) begin
            cls_o  = CLS_SNAP;
            ptr0_o = base_i;
        end else begin
            cls_o = CLS_OK;
        end
    end
endmodule

// File: rtl/ring_step.sv
module ring_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   lim_i,
    input  logic          linear_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW:0] inc_w;

    always_comb begin
        inc_w = {1'b0, ptr_i} + {{AW{1'b0}}, 1'b1};
        if (!linear_i && inc_w == lim_i) nxt_o = base_i;
        else                             nxt_o = inc_w[AW-1:0];
    end
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
    import ring_ptr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          start,
    input  logic          scratch_mode,
    input  logic          wb_en,
    input  logic          step,
    input  logic          finish,
    output logic          busy_o,
    output logic [AW-1:0] addr_o,
    output logic          err_o,
    output logic          done_o,
    output logic [AW-1:0] cur_o
);
    typedef struct packed {
        logic          busy;
        logic          linear;
        logic          scratch;
        logic          wb;
        logic          err;
        logic          done;
        logic [AW-1:0] ptr;
        logic [AW-1:0] cur;
    } st_t;

    st_t st_d, st_q;

    cfg_sel_e      sel_w;
    logic [AW-1:0] base_w, ring_end_w, ptr0_w, nxt_w;
    logic [AW:0]   scr_lim_w, start_lim_w, run_lim_w;
    start_cls_e    cls_w;

    assign sel_w = cfg_sel_e'(cfg_sel);

    ring_cfg_regs #(.AW(AW)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(sel_w), .wdata(cfg_wdata),
        .lock(st_q.busy), .base_o(base_w), .ring_end_o(ring_end_w), .scr_lim_o(scr_lim_w)
    );

    assign start_lim_w = scratch_mode ? scr_lim_w : {1'b0, ring_end_w};
    assign run_lim_w   = st_q.scratch ? scr_lim_w : {1'b0, ring_end_w};

    ring_start_check #(.AW(AW)) chk_i (
        .cur_i(st_q.cur), .base_i(base_w), .lim_i(start_lim_w),
        .scratch_i(scratch_mode), .cls_o(cls_w), .ptr0_o(ptr0_w)
    );

    ring_step #(.AW(AW)) step_i (
        .ptr_i(st_q.ptr), .base_i(base_w), .lim_i(run_lim_w),
        .linear_i(st_q.linear), .nxt_o(nxt_w)
    );

    always_comb begin
        logic [AW-1:0] adv;
        st_d      = st_q;
        st_d.done = 1'b0;
        adv       = step ? nxt_w : st_q.ptr;
        if (!st_q.busy) begin
            if (cfg_we && sel_w == SEL_CUR) st_d.cur = cfg_wdata;
            if (start) begin
                st_d.err     = (cls_w == CLS_FAULT);
                st_d.busy    = (cls_w != CLS_FAULT);
                st_d.linear  = (cls_w == CLS_LINEAR);
                st_d.scratch = scratch_mode;
                st_d.wb      = wb_en;
                if (cls_w != CLS_FAULT) st_d.ptr = ptr0_w;
            end
        end else begin
            st_d.ptr = adv;
            if (finish) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.wb) st_d.cur = adv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign addr_o = st_q.ptr;
    assign err_o  = st_q.err;
    assign done_o = st_q.done;
    assign cur_o  = st_q.cur;

    // R7
    err_excl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.busy);

    // R7
    fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !start) |=> $stable(st_q.ptr));

    // R5
    ptr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.linear && ({1'b0, base_w} < run_lim_w))
        |-> (st_q.ptr >= base_w && {1'b0, st_q.ptr} < run_lim_w));

    // R10
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && finish) |=> (st_q.done && !st_q.busy));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R11
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start && step) |=> $stable(st_q.ptr));

endmodule

// File: tb/ring_ptr_unit_tb.sv
module ring_ptr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int MASK = 32'h00FF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic start = 1'b0, scratch_mode = 1'b0, wb_en = 1'b0, step = 1'b0, finish = 1'b0;
    logic busy_o, err_o, done_o;
    logic [AW-1:0] addr_o, cur_o;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    // behavioural reference state
    int m_base = 0, m_end = 0, m_size = 0, m_cur = 0, m_ptr = 0;
    bit m_busy = 0, m_lin = 0, m_err = 0, m_done = 0, m_scr = 0, m_wb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_ptr_unit #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .scratch_mode(scratch_mode), .wb_en(wb_en), .step(step), .finish(finish),
        .busy_o(busy_o), .addr_o(addr_o), .err_o(err_o), .done_o(done_o), .cur_o(cur_o)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            bit was_busy;
            int lim, p;
            was_busy = m_busy;
            m_done = 0;
            if (!was_busy && start) begin
                lim = scratch_mode ? (m_base + m_size + 1) : m_end;
                m_scr = scratch_mode;
                m_wb  = wb_en;
                if (m_cur >= lim && !scratch_mode) begin
                    m_err = 1;
                end else begin
                    m_err = 0; m_busy = 1;
                    m_lin = (m_cur >= lim);
                    m_ptr = (!m_lin && m_cur < m_base) ? m_base : m_cur;
                end
            end else if (was_busy) begin
                if (step) begin
                    lim = m_scr ? (m_base + m_size + 1) : m_end;
                    p = m_ptr + 1;
                    if (!m_lin && p == lim) p = m_base;
                    m_ptr = p & MASK;
                end
                if (finish) begin
                    m_busy = 0; m_done = 1;
                    if (m_wb) m_cur = m_ptr;
                end
            end
            if (!was_busy && cfg_we) begin
                case (cfg_sel)
                    2'd0: m_base = int'(cfg_wdata);
                    2'd1: m_end  = int'(cfg_wdata);
                    2'd2: m_cur  = int'(cfg_wdata);
                    default: m_size = int'(cfg_wdata);
                endcase
            end
        end
    end

    task automatic cmp1(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cmp1("busy_o", int'(busy_o), int'(m_busy));
        cmp1("addr_o", int'(addr_o), m_ptr);
        cmp1("err_o",  int'(err_o),  int'(m_err));
        cmp1("done_o", int'(done_o), int'(m_done));
        cmp1("cur_o",  int'(cur_o),  m_cur);
    end

    task automatic tick();
        @(negedge clk);
        cfg_we = 0; start = 0; step = 0; finish = 0;
    endtask

    task automatic wr(int sel, int data);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = AW'(data);
        tick();
    endtask

    task automatic go(bit scr, bit wb);
        start = 1; scratch_mode = scr; wb_en = wb;
        tick();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) begin
            step = 1;
            tick();
        end
    endtask

    task automatic fin(bit with_step);
        finish = 1; step = with_step;
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();

        // R2 / R3 / R5 / R6: ring inside, long overrun, writeback
        tag = "R2";
        wr(0, 'h100); wr(1, 'h108); wr(2, 'h104);
        tag = "R3";
        go(0, 1);
        tag = "R5";
        steps(5);
        tag = "R6";
        steps(14);
        tag = "R2";
        wr(2, 'h777); wr(0, 'h50);   // ignored while busy
        tag = "R10";
        fin(0);

        // R11: start while busy, step while idle
        tag = "R11";
        steps(3);
        wr(2, 'h106);
        go(0, 0);
        start = 1; step = 1; scratch_mode = 0; tick();
        steps(2);
        tag = "R10";
        fin(1);                      // no writeback: cur unchanged

        // R4: snap below base
        tag = "R4";
        wr(2, 'h50);
        go(0, 1);
        steps(9);
        tag = "R10";
        fin(1);                      // advance in finish cycle written back

        // R7: fault at and above end
        tag = "R7";
        wr(2, 'h108);
        go(0, 1);
        steps(4);
        wr(2, 'h200);
        go(0, 0);
        steps(2);
        wr(2, 'h101);
        go(0, 0);                    // clears err
        steps(2);
        fin(0);

        // R8: scratch ring via size minus one
        tag = "R8";
        wr(0, 'h200); wr(3, 3); wr(1, 'h10); wr(2, 'h201);
        go(1, 1);
        steps(9);
        fin(0);
        // R8: region ending at top of address space
        wr(0, 'hFFFFFC); wr(3, 3); wr(2, 'hFFFFFE);
        go(1, 1);
        steps(6);
        fin(1);

        // R9: scratch start beyond region runs linearly
        tag = "R9";
        wr(0, 'h300); wr(3, 7); wr(2, 'h308);
        go(1, 1);
        steps(5);
        fin(0);
        wr(2, 'h30A);
        go(1, 0);
        steps(3);
        fin(1);

        tick(); tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule